// File: doc/BRIEF.md
# GPIO Event Detector with Grouped Interrupts

This block watches 54 general-purpose pin inputs and records events on them in a sticky status register. Six detector kinds can be enabled per pin: rising and falling edges taken from samples that were synchronized outside the block, high and low levels on those same samples, and rising and falling edges taken from a short path on the raw pin. That short path is a single capture flop, so it can catch narrower pulses. Every enabled detector on a pin feeds the same status bit. The bit stays set until software writes a one to it.

The status bits are grouped into three interrupt lines, each covering a fixed pin range. The ranges do not follow the 32-bit register banks: the middle line takes the top four bits of bank 0 and the low fourteen bits of bank 1. Software reaches the enables and the status through a 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the address.

There is no control state machine. The whole block is registers and combinational decode. All state returns to zero on reset.

Top module: `gpio_event_unit`

## Requirements
- R1: After reset every enable register, both status words and all three interrupt lines read 0.
- R2: Enable words live at byte offsets 0x4C (sync rising), 0x58 (sync falling), 0x64 (high level), 0x70 (low level), 0x7C (raw rising) and 0x88 (raw falling), each plus 4 for bank 1. Bit i of bank b controls pin 32*b+i. They read back as written, except that bank 1 bits 22 to 31 read 0.
- R3: With sync rising enabled, the status bit is set on the clock edge at which the synchronized input is 1 and its previous-edge sample was 0.
- R4: With sync falling enabled, a 1-to-0 step sets the status bit. With both rising and falling enabled, either edge sets it.
- R5: With high (low) level enabled, the status bit is set on every edge at which the synchronized input is 1 (0). A clear written while the level still holds leaves the bit reading 1 on the next cycle.
- R6: The raw input is captured by one flop, and raw edges compare that flop with its own previous value. A raw rising change sets status on the second clock edge after the change, a raw falling change on the second edge after it falls. A one-cycle raw pulse is detected.
- R7: Writing to 0x40 (bank 0) or 0x44 (bank 1) clears each status bit written as 1. Bits written as 0 are unchanged. Status reads back at those same offsets, bit i of bank b for pin 32*b+i.
- R8: When a clear and a new event hit the same bit on the same edge, the bit stays set.
- R9: Detectors that are not enabled never set status. Status bits already set stay set after their enables are removed, until they are cleared.
- R10: Interrupt line 0 is the OR of status for pins 0 to 27, line 1 for pins 28 to 45, and line 2 for pins 46 to 53.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_sync | input | 54 | Pin levels already synchronized outside the block |
| pins_raw | input | 54 | Raw pin levels for the short edge path |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address of the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 3 | Grouped interrupt lines |

## Verification
The bench aims at the group split points: pins 27/28 and 45/46, and pin 53 at the top of bank 1. A design that sliced the status vector by bank instead of by pin range would raise the wrong line at these pins. It also lines a clear write up on the same edge as a fresh edge event. A design that let the clear win would drop that event without any trace. It counts the edges before a raw-path event appears and sends a single-cycle raw pulse. An extra or a missing capture stage moves the set by one cycle, and the model compared on every clock catches that shift. It also checks that bank 1 bits above pin 53 read 0, that clears written while a level condition still holds have no lasting effect, and that latched bits survive the removal of their enables.

// File: rtl/gpev_pkg.sv
package gpev_pkg;
    localparam int BANK_W      = 32;
    localparam int NUM_MODES   = 6;
    localparam int STAT_OFS    = 'h40;
    localparam int EN_OFS      = 'h4C;
    localparam int MODE_STRIDE = 12;
    localparam int BANK_STRIDE = 4;

    // Detector kinds; the value is the index of the enable word group.
    typedef enum logic [2:0] {
        MD_RISE  = 3'd0,
        MD_FALL  = 3'd1,
        MD_HIGH  = 3'd2,
        MD_LOW   = 3'd3,
        MD_ARISE = 3'd4,
        MD_AFALL = 3'd5
    } det_mode_e;

    function automatic int en_addr(input int mode, input int bank);
        return EN_OFS + mode * MODE_STRIDE + bank * BANK_STRIDE;
    endfunction

    function automatic int stat_addr(input int bank);
        return STAT_OFS + bank * BANK_STRIDE;
    endfunction
endpackage

// File: rtl/gpev_enables.sv
module gpev_enables
    import gpev_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int ADDR_W   = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [BANK_W-1:0]                   wdata,
    output logic [NUM_MODES-1:0][NUM_PINS-1:0]  en_q,
    output logic [BANK_W-1:0]                   rdata
);
    localparam int NB = (NUM_PINS + BANK_W - 1) / BANK_W;

    // Each pin bit is written from the word that maps it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            for (int m = 0; m < NUM_MODES; m++) begin
                for (int i = 0; i < NUM_PINS; i++) begin
                    if (addr == ADDR_W'(en_addr(m, i / BANK_W)))
                        en_q[m][i] <= wdata[i % BANK_W];
                end
            end
        end
    end

    // Bits past the last pin read as zero.
    always_comb begin
        rdata = '0;
        for (int m = 0; m < NUM_MODES; m++) begin
            for (int b = 0; b < NB; b++) begin
                if (addr == ADDR_W'(en_addr(m, b))) begin
                    for (int k = 0; k < BANK_W; k++) begin
                        if (b * BANK_W + k < NUM_PINS)
                            rdata[k] = en_q[m][b * BANK_W + k];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/gpev_detect.sv
module gpev_detect
    import gpev_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_PINS-1:0]                 pins_sync,
    input  logic [NUM_PINS-1:0]                 pins_raw,
    input  logic [NUM_MODES-1:0][NUM_PINS-1:0]  en,
    output logic [NUM_PINS-1:0]                 evt
);
    logic [NUM_PINS-1:0] sync_prev;
    logic [NUM_PINS-1:0] raw_cap;
    logic [NUM_PINS-1:0] raw_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_prev <= '0;
            raw_cap   <= '0;
            raw_prev  <= '0;
        end else begin
            sync_prev <= pins_sync;
            raw_cap   <= pins_raw;
            raw_prev  <= raw_cap;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic s_rise, s_fall, r_rise, r_fall;
        assign s_rise = pins_sync[i] & ~sync_prev[i];
        assign s_fall = ~pins_sync[i] & sync_prev[i];
        assign r_rise = raw_cap[i] & ~raw_prev[i];
        assign r_fall = ~raw_cap[i] & raw_prev[i];
        assign evt[i] = (en[int'(MD_RISE)][i]  & s_rise)
                      | (en[int'(MD_FALL)][i]  & s_fall)
                      | (en[int'(MD_HIGH)][i]  & pins_sync[i])
                      | (en[int'(MD_LOW)][i]   & ~pins_sync[i])
                      | (en[int'(MD_ARISE)][i] & r_rise)
                      | (en[int'(MD_AFALL)][i] & r_fall);
    end
endmodule

// File: rtl/gpev_status.sv
module gpev_status
    import gpev_pkg::*;
#(
    parameter int NUM_PINS   = 54,
    parameter int ADDR_W     = 8,
    parameter int IRQ1_FIRST = 28,
    parameter int IRQ2_FIRST = 46
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [BANK_W-1:0]    wdata,
    input  logic [NUM_PINS-1:0]  evt,
    output logic [NUM_PINS-1:0]  status_q,
    output logic [BANK_W-1:0]    rdata,
    output logic [2:0]           irq
);
    localparam int NB = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int GRP_LO [3] = '{0, IRQ1_FIRST, IRQ2_FIRST};
    localparam int GRP_HI [3] = '{IRQ1_FIRST - 1, IRQ2_FIRST - 1, NUM_PINS - 1};

    logic [NUM_PINS-1:0] clr;

    always_comb begin
        clr = '0;
        if (wr_en) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                if (addr == ADDR_W'(stat_addr(i / BANK_W)))
                    clr[i] = wdata[i % BANK_W];
            end
        end
    end

    // A new event outranks a clear of the same bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | evt;
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NB; b++) begin
            if (addr == ADDR_W'(stat_addr(b))) begin
                for (int k = 0; k < BANK_W; k++) begin
                    if (b * BANK_W + k < NUM_PINS)
                        rdata[k] = status_q[b * BANK_W + k];
                end
            end
        end
    end

    for (genvar g = 0; g < 3; g++) begin : g_irq
        assign irq[g] = |status_q[GRP_HI[g]:GRP_LO[g]];
    end
endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit
    import gpev_pkg::*;
#(
    parameter int NUM_PINS   = 54,
    parameter int ADDR_W     = 8,
    parameter int IRQ1_FIRST = 28,
    parameter int IRQ2_FIRST = 46
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_sync,
    input  logic [NUM_PINS-1:0] pins_raw,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [BANK_W-1:0]   reg_wdata,
    output logic [BANK_W-1:0]   reg_rdata,
    output logic [2:0]          irq
);
    logic [NUM_MODES-1:0][NUM_PINS-1:0] en_vec;
    logic [NUM_PINS-1:0]                det_evt;
    logic [NUM_PINS-1:0]                stat_vec;
    logic [BANK_W-1:0]                  en_rdata;
    logic [BANK_W-1:0]                  st_rdata;

    gpev_enables #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_en (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .en_q(en_vec), .rdata(en_rdata)
    );

    gpev_detect #(.NUM_PINS(NUM_PINS)) u_det (
        .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync), .pins_raw(pins_raw),
        .en(en_vec), .evt(det_evt)
    );

    gpev_status #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W),
                  .IRQ1_FIRST(IRQ1_FIRST), .IRQ2_FIRST(IRQ2_FIRST)) u_st (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .evt(det_evt), .status_q(stat_vec),
        .rdata(st_rdata), .irq(irq)
    );

    // Address ranges are disjoint, so at most one side is nonzero.
    assign reg_rdata = en_rdata | st_rdata;
endmodule

// File: rtl/gpio_event_unit_chk.sv
module gpio_event_unit_chk
    import gpev_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int ADDR_W   = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          reg_wr,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [BANK_W-1:0]             reg_wdata,
    input logic [NUM_MODES*NUM_PINS-1:0] en_flat,
    input logic [NUM_PINS-1:0]           evt,
    input logic [NUM_PINS-1:0]           stat,
    input logic [2:0]                    irq
);
    logic stat_wr;
    assign stat_wr = reg_wr && ((reg_addr == ADDR_W'(stat_addr(0))) ||
                                (reg_addr == ADDR_W'(stat_addr(1))));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_flat == '0 && stat == '0) |=> stat == '0);

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> (stat & $past(stat)) == $past(stat));

    // R7
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(stat_addr(0)) && evt[BANK_W-1:0] == '0)
        |=> (stat[BANK_W-1:0] & $past(reg_wdata)) == '0);

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat & $past(evt)) == $past(evt));

    // R10
    irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != 3'b000) == (stat != '0));
endmodule

bind gpio_event_unit gpio_event_unit_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .en_flat(en_vec), .evt(det_evt), .stat(stat_vec),
    .irq(irq)
);

// File: tb/gpio_event_unit_test.sv
`timescale 1ns/1ps
module gpio_event_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [53:0] pins_sync = '0;
    logic [53:0] pins_raw = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [2:0]  irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_event_unit uut (
        .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync), .pins_raw(pins_raw),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // Behavioural reference model
    bit [63:0] m_en [6];
    bit [53:0] m_stat, m_sp, m_ac, m_ap;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int m = 0; m < 6; m++) m_en[m] = '0;
            m_stat = '0; m_sp = '0; m_ac = '0; m_ap = '0;
        end else begin
            bit [53:0] ev;
            bit [63:0] clr;
            ev = '0;
            for (int i = 0; i < 54; i++) begin
                if (m_en[0][i] && pins_sync[i] && !m_sp[i]) ev[i] = 1'b1;
                if (m_en[1][i] && !pins_sync[i] && m_sp[i]) ev[i] = 1'b1;
                if (m_en[2][i] && pins_sync[i]) ev[i] = 1'b1;
                if (m_en[3][i] && !pins_sync[i]) ev[i] = 1'b1;
                if (m_en[4][i] && m_ac[i] && !m_ap[i]) ev[i] = 1'b1;
                if (m_en[5][i] && !m_ac[i] && m_ap[i]) ev[i] = 1'b1;
            end
            clr = '0;
            if (reg_wr && reg_addr == 8'h40) clr[31:0] = reg_wdata;
            if (reg_wr && reg_addr == 8'h44) clr[63:32] = reg_wdata;
            m_stat = (m_stat & ~clr[53:0]) | ev;
            m_sp = pins_sync;
            m_ap = m_ac;
            m_ac = pins_raw;
            if (reg_wr) begin
                for (int m = 0; m < 6; m++)
                    for (int b = 0; b < 2; b++)
                        if (int'(reg_addr) == 'h4C + m * 12 + b * 4)
                            m_en[m][b*32 +: 32] = reg_wdata;
                for (int m = 0; m < 6; m++) m_en[m][63:54] = '0;
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        bit [63:0] s;
        s = {10'b0, m_stat};
        if (a == 8'h40) return s[31:0];
        if (a == 8'h44) return s[63:32];
        for (int m = 0; m < 6; m++)
            for (int b = 0; b < 2; b++)
                if (int'(a) == 'h4C + m * 12 + b * 4) return m_en[m][b*32 +: 32];
        return 32'h0;
    endfunction

    function automatic logic [2:0] model_irq();
        logic [2:0] r;
        r = '0;
        for (int i = 0; i < 54; i++) begin
            if (m_stat[i]) begin
                if (i < 28) r[0] = 1'b1;
                else if (i < 46) r[1] = 1'b1;
                else r[2] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R10: interrupt lines compared with the model on every clock
    always @(negedge clk) begin
        if (rst_n) check("R10 per-cycle irq", {29'b0, irq}, {29'b0, model_irq()});
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag, input logic [31:0] lit);
        @(negedge clk);
        reg_addr = a;
        #1;
        check({tag, " model"}, reg_rdata, model_read(a));
        check({tag, " expected"}, reg_rdata, lit);
    endtask

    task automatic irq_at_pin(input int p, input logic [2:0] exp);
        logic [7:0] ea, sa;
        logic [31:0] bitv;
        ea = (p < 32) ? 8'h64 : 8'h68;
        sa = (p < 32) ? 8'h40 : 8'h44;
        bitv = 32'h1 << (p % 32);
        @(negedge clk) pins_sync[p] = 1'b1;
        wr(ea, bitv);
        @(negedge clk);
        check($sformatf("R10 pin %0d irq", p), {29'b0, irq}, {29'b0, exp});
        pins_sync[p] = 1'b0;
        wr(ea, 32'h0);
        wr(sa, bitv);
        @(negedge clk);
        check($sformatf("R10 pin %0d irq cleared", p), {29'b0, irq}, 32'h0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h40, "R1 status0", 32'h0);
        rd(8'h44, "R1 status1", 32'h0);
        rd(8'h4C, "R1 rise0", 32'h0);
        rd(8'h8C, "R1 afall1", 32'h0);
        check("R1 irq", {29'b0, irq}, 32'h0);

        // R2: enable readback, unused bank 1 bits read 0
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, "R2 rise1 mask", 32'h003F_FFFF);
        wr(8'h7C, 32'hA5A5_A5A5);
        rd(8'h7C, "R2 arise0", 32'hA5A5_A5A5);
        wr(8'h50, 32'h0);
        wr(8'h7C, 32'h0);

        // R3: synchronous rising
        wr(8'h4C, 32'h8);
        @(negedge clk) pins_sync[3] = 1'b1;
        rd(8'h40, "R3 rise pin3", 32'h8);
        wr(8'h40, 32'h8);
        rd(8'h40, "R3 held high no re-set", 32'h0);
        @(negedge clk) pins_sync[3] = 1'b0;
        rd(8'h40, "R9 fall not enabled", 32'h0);

        // R4: both edges on pin 30
        wr(8'h4C, 32'h4000_0000);
        wr(8'h58, 32'h4000_0000);
        @(negedge clk) pins_sync[30] = 1'b1;
        rd(8'h40, "R4 rise of both", 32'h4000_0000);
        check("R4 irq line1", {29'b0, irq}, 32'h2);
        wr(8'h40, 32'h4000_0000);
        @(negedge clk) pins_sync[30] = 1'b0;
        rd(8'h40, "R4 fall of both", 32'h4000_0000);
        wr(8'h40, 32'h4000_0000);
        rd(8'h40, "R4 cleared", 32'h0);

        // R5: high level on pin 40, low level on pin 50
        wr(8'h68, 32'h100);
        @(negedge clk) pins_sync[40] = 1'b1;
        rd(8'h44, "R5 high pin40", 32'h100);
        wr(8'h44, 32'h100);
        rd(8'h44, "R5 re-set while held", 32'h100);
        @(negedge clk) pins_sync[40] = 1'b0;
        wr(8'h68, 32'h0);
        wr(8'h44, 32'h100);
        rd(8'h44, "R5 high cleared", 32'h0);
        wr(8'h74, 32'h4_0000);
        rd(8'h44, "R5 low pin50", 32'h4_0000);
        check("R5 irq line2", {29'b0, irq}, 32'h4);
        @(negedge clk) pins_sync[50] = 1'b1;
        wr(8'h74, 32'h0);
        wr(8'h44, 32'h4_0000);
        rd(8'h44, "R5 low cleared", 32'h0);

        // R6: raw path, one-cycle pulse on pin 47
        wr(8'h80, 32'h8000);
        @(negedge clk) pins_raw[47] = 1'b1;
        @(negedge clk) pins_raw[47] = 1'b0;
        rd(8'h44, "R6 raw rise pulse", 32'h8000);
        wr(8'h80, 32'h0);
        wr(8'h44, 32'h8000);
        wr(8'h8C, 32'h8000);
        @(negedge clk) pins_raw[47] = 1'b1;
        @(negedge clk) pins_raw[47] = 1'b0;
        rd(8'h44, "R6 raw fall not yet", 32'h0);
        rd(8'h44, "R6 raw fall", 32'h8000);
        wr(8'h8C, 32'h0);
        wr(8'h44, 32'h8000);
        rd(8'h44, "R6 cleared", 32'h0);

        // R7: partial write-one clear
        wr(8'h58, 32'h0);
        wr(8'h4C, 32'h6);
        @(negedge clk) begin pins_sync[1] = 1'b1; pins_sync[2] = 1'b1; end
        rd(8'h40, "R7 two bits", 32'h6);
        wr(8'h40, 32'h2);
        rd(8'h40, "R7 zero bits kept", 32'h4);

        // R8: clear and new event on the same edge
        @(negedge clk) pins_sync[2] = 1'b0;
        @(negedge clk);
        pins_sync[2] = 1'b1;
        reg_wr = 1'b1; reg_addr = 8'h40; reg_wdata = 32'h4;
        @(negedge clk) reg_wr = 1'b0;
        rd(8'h40, "R8 event wins", 32'h4);

        // R9: sticky after enables removed, disabled pins ignored
        wr(8'h4C, 32'h0);
        rd(8'h40, "R9 sticky", 32'h4);
        @(negedge clk) begin pins_sync[10] = 1'b1; pins_raw[10] = 1'b1; end
        repeat (3) @(negedge clk);
        rd(8'h40, "R9 disabled pin10", 32'h4);
        wr(8'h40, 32'h4);
        rd(8'h40, "R9 cleared", 32'h0);
        pins_sync[10] = 1'b0; pins_raw[10] = 1'b0;
        pins_sync[1] = 1'b0; pins_sync[2] = 1'b0;

        // R10: group boundaries
        irq_at_pin(27, 3'b001);
        irq_at_pin(28, 3'b010);
        irq_at_pin(45, 3'b010);
        irq_at_pin(46, 3'b100);
        irq_at_pin(53, 3'b100);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule